// File: doc/BRIEF.md
# Clock Generator Interrupt Flag Unit

This block holds the interrupt flags and enables for a clock and reset generator. It has three sources. The first is a periodic real-time timeout, which arrives as a one-cycle tick. The second is any change of the PLL lock level, up or down. The third is any entry into or exit from self-clock mode. The self-clock-mode level is built inside the block: a failed clock quality check is always part of it, and a lost external clock is part of it only while the clock monitor is enabled. Both level inputs are asynchronous. Each one goes through a two-flop synchronizer, and an edge detector then produces exactly one set pulse per transition.

Software reaches the block through a plain register port with two addresses. A write at address 0 clears flags: each bit written as 1 clears that flag. A write at address 1 loads the enable register. Reads are combinational. Each interrupt request is its flag ANDed with its enable. The block has no streaming data path, so every pin is a plain control or status level with no valid/ready handshake.

Top module: `cgi_irq_flags`

## Requirements
- R1: After reset, all flags, all enables, all interrupt requests and the read data of address 1 are 0. Input levels held steady across reset release set no flag.
- R2: Outside pseudo stop, a one-cycle `rti_tick_i` sets the real-time flag (flag bit 0) at the next clock edge.
- R3: While `pseudo_stop_i` is 1, a tick sets no flag unless the run-in-stop enable bit (address 1, bit 3) is 1.
- R4: Each change of `pll_lock_i` sets the lock flag (flag bit 1), for a rise and for a fall alike. The flag is set at the third clock edge that samples the new level.
- R5: Each change of the self-clock-mode level (`qc_fail_i` OR (`ext_clk_lost_i` AND monitor enable)) sets the self-clock flag (flag bit 2). The latency is the same as in R4.
- R6: While the monitor enable bit (address 1, bit 4) is 0, changes of `ext_clk_lost_i` have no effect on the self-clock flag.
- R7: Writing address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R8: If a set event and a clearing write reach the same flag in the same cycle, the flag ends up 1.
- R9: Each request output equals its flag AND its enable (address 1, bits 0/1/2 for real-time/lock/self-clock). Enabling a source whose flag is already set raises its request right after the write.
- R10: Reading address 0 returns {3'b0, synced self-clock level, synced lock level, self-clock flag, lock flag, real-time flag}. Reading address 1 returns {3'b0, monitor enable, run-in-stop, self-clock enable, lock enable, real-time enable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rti_tick_i | input | 1 | One-cycle real-time timeout pulse |
| pll_lock_i | input | 1 | Asynchronous PLL lock level |
| qc_fail_i | input | 1 | Asynchronous clock-quality-failure level |
| ext_clk_lost_i | input | 1 | Asynchronous external-clock-lost level |
| pseudo_stop_i | input | 1 | Pseudo stop mode indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 clears flags, 1 loads enables |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| irq_rti_o | output | 1 | Real-time interrupt request |
| irq_lock_o | output | 1 | Lock-change interrupt request |
| irq_scm_o | output | 1 | Self-clock-change interrupt request |
| flags_o | output | 3 | Flags {self-clock, lock, real-time} |

## Verification
The bench holds the lock level high through reset. A design that let its previous-level register start at 0 would raise a false lock flag just after release. The bench fires a tick while a clearing write is applied to the same flag. A design where the clear wins would lose that event. The bench drives lock falls as well as rises, and it toggles the external-clock-lost input while the monitor is disabled. A detector that fired on one direction only, or that ignored the monitor gate, would show up as a flag mismatch in the cycle-by-cycle model comparison. Ticks in pseudo stop with the run-in-stop bit clear must leave the real-time flag at 0.

// File: rtl/cgi_pkg.sv
package cgi_pkg;
  localparam int NSRC     = 3;
  localparam int REG_W    = 8;
  localparam int SYNC_LEN = 2;
  localparam int SRC_RTI  = 0;
  localparam int SRC_LOCK = 1;
  localparam int SRC_SCM  = 2;
  localparam int EN_RUN_STOP = 3;
  localparam int EN_MON      = 4;
endpackage

// File: rtl/cgi_sync.sv
module cgi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cgi_chg_det.sv
module cgi_chg_det #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic chg
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] settle_cnt;
  logic          prev;
  logic          armed;

  assign armed = (settle_cnt == CW'(SETTLE));
  assign chg   = armed && (lvl != prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      prev       <= 1'b0;
    end else begin
      prev <= lvl;
      if (!armed) settle_cnt <= settle_cnt + 1'b1;
    end
  end

  // R1: a freshly reset detector stays quiet until the synchronizer has filled
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt == '0) |=> !chg);
endmodule

// File: rtl/cgi_flag.sv
module cgi_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(flag));
endmodule

// File: rtl/cgi_irq_flags.sv
module cgi_irq_flags
  import cgi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rti_tick_i,
  input  logic             pll_lock_i,
  input  logic             qc_fail_i,
  input  logic             ext_clk_lost_i,
  input  logic             pseudo_stop_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_rti_o,
  output logic             irq_lock_o,
  output logic             irq_scm_o,
  output logic [NSRC-1:0]  flags_o
);
  localparam int SETTLE = SYNC_LEN + 1;
  localparam int NLVL   = 2;

  logic [REG_W-1:0] en_q;
  logic [NSRC-1:0]  set_ev, clr_ev, flag_q, irq;
  logic [NLVL-1:0]  lvl_raw, lvl_sync, lvl_chg;
  logic             rti_live;

  // Enable register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       en_q <= '0;
    else if (wr_en_i && wr_addr_i)    en_q <= {3'b000, wr_data_i[4:0]};
  end

  // Self-clock level: quality failure always, lost clock only when monitored
  assign lvl_raw[0] = pll_lock_i;
  assign lvl_raw[1] = qc_fail_i | (ext_clk_lost_i & en_q[EN_MON]);

  generate
    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
      cgi_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(lvl_raw[i]), .q(lvl_sync[i]));
      cgi_chg_det #(.SETTLE(SETTLE)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_sync[i]), .chg(lvl_chg[i]));
    end
  endgenerate

  assign rti_live           = !pseudo_stop_i || en_q[EN_RUN_STOP];
  assign set_ev[SRC_RTI]    = rti_tick_i && rti_live;
  assign set_ev[SRC_LOCK]   = lvl_chg[0];
  assign set_ev[SRC_SCM]    = lvl_chg[1];

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign clr_ev[s] = wr_en_i && !wr_addr_i && wr_data_i[s];
      cgi_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(set_ev[s]), .clr(clr_ev[s]), .flag(flag_q[s]));
      assign irq[s] = flag_q[s] & en_q[s];
    end
  endgenerate

  assign flags_o    = flag_q;
  assign irq_rti_o  = irq[SRC_RTI];
  assign irq_lock_o = irq[SRC_LOCK];
  assign irq_scm_o  = irq[SRC_SCM];

  always_comb begin
    if (rd_addr_i) rd_data_o = en_q;
    else           rd_data_o = {3'b000, lvl_sync[1], lvl_sync[0], flag_q};
  end

  // R3: a gated tick in pseudo stop cannot raise the real-time flag
  assert_stop_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pseudo_stop_i && !en_q[EN_RUN_STOP] && !flag_q[SRC_RTI]) |=> !flag_q[SRC_RTI]);
  // R4: a rising lock flag always follows a detected lock transition
  assert_lock_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_LOCK]) |-> $past(lvl_chg[0]));
  // R9: no request without its enable
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[SRC_SCM] |-> !irq_scm_o);
endmodule

// File: tb/cgi_irq_flags_tb.sv
`timescale 1ns/100ps
module cgi_irq_flags_tb;
  logic       clk = 0, rst_n = 0;
  logic       tick = 0, lock = 1, qc = 0, lost = 0, ps = 0;
  logic       wen = 0, waddr = 0, raddr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq_r, irq_l, irq_s;
  logic [2:0] flags;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  cgi_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .rti_tick_i(tick), .pll_lock_i(lock), .qc_fail_i(qc),
    .ext_clk_lost_i(lost), .pseudo_stop_i(ps), .wr_en_i(wen), .wr_addr_i(waddr),
    .wr_data_i(wdata), .rd_addr_i(raddr), .rd_data_o(rdata), .irq_rti_o(irq_r),
    .irq_lock_o(irq_l), .irq_scm_o(irq_s), .flags_o(flags));

  // Behavioural reference model
  bit   mf[3];
  bit   men[5];
  bit   lq[$], sq[$];
  int   edges = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (mf[i]) mf[i] = 0;
      foreach (men[i]) men[i] = 0;
      lq.delete(); sq.delete(); edges = 0;
    end else begin
      bit sev[3];
      bit scm_lvl;
      edges++;
      scm_lvl = qc || (lost && men[4]);
      lq.push_back(lock); sq.push_back(scm_lvl);
      if (lq.size() > 4) begin void'(lq.pop_front()); void'(sq.pop_front()); end
      sev[0] = tick && (!ps || men[3]);
      sev[1] = (edges >= 4) && (lq[0] != lq[1]);
      sev[2] = (edges >= 4) && (sq[0] != sq[1]);
      for (int i = 0; i < 3; i++) begin
        bit c;
        c = wen && !waddr && wdata[i];
        mf[i] = sev[i] || (mf[i] && !c);
      end
      if (wen && waddr) for (int i = 0; i < 5; i++) men[i] = wdata[i];
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit lsync(bit q[$]);
    return (q.size() >= 2) ? q[q.size()-2] : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] er;
      chk("R2 rti flag", flags[0], mf[0]);
      chk("R4 lock flag", flags[1], mf[1]);
      chk("R5 scm flag", flags[2], mf[2]);
      chk("R9 irq", {irq_s, irq_l, irq_r}, {mf[2] & men[2], mf[1] & men[1], mf[0] & men[0]});
      if (raddr) er = {3'b0, men[4], men[3], men[2], men[1], men[0]};
      else       er = {3'b0, lsync(sq), lsync(lq), mf[2], mf[1], mf[0]};
      chk("R10 read", rdata, er);
    end
  end

  always @(posedge clk) #1 raddr <= ~raddr;

  task automatic cyc_n(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit a, logic [7:0] d);
    wen = 1; waddr = a; wdata = d;
    cyc_n(1);
    wen = 0; wdata = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; cyc_n(1); tick = 0;
  endtask

  task automatic peek_flags(string tag, logic [2:0] exp);
    @(negedge clk);
    chk(tag, flags, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    join_none
    cyc_n(3);
    rst_n = 1;
    cyc_n(8);
    // R1: stable lock high through reset release flags nothing
    @(negedge clk);
    chk("R1 flags after reset", flags, 0);
    chk("R1 irqs after reset", {irq_s, irq_l, irq_r}, 0);
    @(posedge clk); #1;
    // R2
    pulse_tick();
    peek_flags("R2 tick sets flag", 3'b001);
    // R7: zero write leaves it, one write clears it
    wr(0, 8'h00); peek_flags("R7 zero write no effect", 3'b001);
    wr(0, 8'h01); peek_flags("R7 one write clears", 3'b000);
    // R3
    ps = 1; pulse_tick(); peek_flags("R3 tick gated in pseudo stop", 3'b000);
    wr(1, 8'h08); pulse_tick(); peek_flags("R3 run-in-stop lets tick through", 3'b001);
    wr(0, 8'h01); ps = 0;
    // R4 fall then rise
    lock = 0; cyc_n(5); peek_flags("R4 lock fall", 3'b010);
    wr(0, 8'h02); cyc_n(2); peek_flags("R4 single event per change", 3'b000);
    lock = 1; cyc_n(5); peek_flags("R4 lock rise", 3'b010);
    wr(0, 8'h02);
    // R6: lost clock unmonitored
    lost = 1; cyc_n(6); peek_flags("R6 lost ignored without monitor", 3'b000);
    // R5: enabling monitor makes the level rise
    wr(1, 8'h10); cyc_n(5); peek_flags("R5 scm entry", 3'b100);
    wr(0, 8'h04);
    lost = 0; cyc_n(5); peek_flags("R5 scm exit", 3'b100);
    wr(0, 8'h04);
    qc = 1; cyc_n(5); peek_flags("R5 quality fail entry", 3'b100);
    wr(0, 8'h04); qc = 0; cyc_n(5); wr(0, 8'h07);
    // R8: set and clear in one cycle
    tick = 1; wen = 1; waddr = 0; wdata = 8'h01; cyc_n(1);
    tick = 0; wen = 0; wdata = 0;
    peek_flags("R8 set wins over clear", 3'b001);
    // R9: enable with flag already set
    @(negedge clk); chk("R9 masked irq", irq_r, 0); @(posedge clk); #1;
    wr(1, 8'h01);
    @(negedge clk); chk("R9 irq on enable", irq_r, 1); @(posedge clk); #1;
    wr(1, 8'h07); lock = 0; cyc_n(5);
    @(negedge clk); chk("R9 lock irq", irq_l, 1);
    cyc_n(4);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule